// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block chooses which of several DMA channels may use a single shared transfer engine. Each channel presents a request, a mode bit that picks burst or cycle-steal operation, and a flag that is high once its programmed transfer count has run out. The engine reports the end of every transfer unit with a one-cycle done strobe. The arbiter issues a registered one-hot grant. It changes that grant only at a unit boundary, or while no channel holds it.

A single mode input selects the priority scheme. In fixed mode the lowest channel number always wins. A higher request therefore cuts into a lower burst at the next boundary and keeps the engine until its whole count is finished. In rotating mode the channel that has just moved a unit drops to the lowest priority. Contending channels therefore take turns one unit at a time. A burst channel that loses the grant while still eligible is marked suspended. It keeps its claim without holding its request, and a one-cycle resume pulse marks the cycle in which it gets the engine back.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, and in every cycle, the grant has at most one bit set. Reset clears the grant, the suspended flags and the resume pulses.
- R2: While a channel holds the grant, the grant does not change in any cycle without the unit-done strobe.
- R3: In fixed mode, a decision grants the eligible channel with the lowest index. A channel is eligible when its request or its suspended flag is set and its count-complete flag is clear.
- R4: A burst channel that holds the grant, is still eligible at a boundary and loses the grant there is marked suspended in the same cycle the grant moves.
- R5: In fixed mode, a suspended lower channel gets the grant back only at the boundary where every higher eligible channel has finished its count.
- R6: In rotating mode, the channel that has just finished a unit becomes the lowest priority. After reset channel 0 is highest, and an idle decision starts the search just after the last channel served.
- R7: In rotating mode, two eligible channels alternate the grant at every unit boundary until one of them completes.
- R8: A cycle-steal channel that loses the grant at a boundary is not marked suspended. It competes again only through its request.
- R9: A suspended channel is granted again even when its request input is low.
- R10: A channel whose request drops, or whose count-complete flag is set, is not granted at the next decision. A set count-complete flag clears that channel's suspended flag.
- R11: The resume output of a channel pulses for exactly one cycle, in the first cycle that a previously suspended channel holds the grant again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rr_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| req | input | NCH | Per-channel transfer request |
| burst_mode | input | NCH | Per-channel mode: 1 = burst, 0 = cycle steal |
| cnt_done | input | NCH | Per-channel count-complete flag |
| unit_done | input | 1 | Strobe: the granted channel finished one transfer unit |
| grant | output | NCH | Registered one-hot grant |
| suspended | output | NCH | Registered per-channel suspended status |
| resumed | output | NCH | One-cycle pulse when a suspended channel is granted again |

## Verification
The bench drives a channel 0 request into the middle of a channel 1 burst. A design that preempted at once, rather than at the boundary, would move the grant a cycle early. A design that let the burst run on would never move it. In fixed mode the bench then drops the suspended channel's request to check that it still comes back, and only after channel 0 reports its count complete. A design that forgot the suspension would leave the engine idle, and one that resumed early would show the pulse too soon. In rotating mode the bench checks the alternation order, the start at channel 0 after reset, and that a completion flag on a suspended channel clears it. A design with a wrong rotation pointer would pick the wrong channel on the idle decision.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic {
    PRIO_FIXED  = 1'b0,
    PRIO_ROTATE = 1'b1
  } prio_mode_e;

endpackage

// File: rtl/dma_arb_fixed_pick.sv
module dma_arb_fixed_pick #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0] cand,
  output logic [NCH-1:0] pick
);

  // Lowest index wins.
  always_comb begin
    logic found;
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (!found && cand[i]) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_arb_rot_pick.sv
module dma_arb_rot_pick #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic [NCH-1:0] cand,
  input  logic [CW-1:0]  last,
  output logic [NCH-1:0] pick
);

  // Search starts just after the last channel served; that channel is checked last.
  always_comb begin
    logic found;
    pick  = '0;
    found = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      if (!found && cand[(int'(last) + k) % NCH]) begin
        pick[(int'(last) + k) % NCH] = 1'b1;
        found = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_arb_chan_track.sv
module dma_arb_chan_track (
  input  logic clk,
  input  logic rst,
  input  logic decide,
  input  logic boundary,
  input  logic held,
  input  logic burst,
  input  logic active,
  input  logic win,
  input  logic cnt_done,
  output logic susp,
  output logic res
);

  always_ff @(posedge clk) begin
    if (rst) begin
      susp <= 1'b0;
      res  <= 1'b0;
    end else begin
      res <= decide & win & susp;
      if (decide && win)
        susp <= 1'b0;
      else if (cnt_done)
        susp <= 1'b0;
      else if (boundary && held && burst && active)
        susp <= 1'b1;
    end
  end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rr_mode,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] burst_mode,
  input  logic [NCH-1:0] cnt_done,
  input  logic           unit_done,
  output logic [NCH-1:0] grant,
  output logic [NCH-1:0] suspended,
  output logic [NCH-1:0] resumed
);

  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  prio_mode_e     mode;
  logic [NCH-1:0] grant_q, grant_nx, susp_q, res_q, active;
  logic [NCH-1:0] pick_fixed, pick_rot;
  logic [CW-1:0]  cur_idx, last_q, last_sel;
  logic           busy, boundary, decide;

  assign mode = rr_mode ? PRIO_ROTATE : PRIO_FIXED;

  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < NCH; i++)
      if (grant_q[i]) cur_idx = CW'(i);
  end

  assign busy     = |grant_q;
  assign boundary = unit_done & busy;
  assign decide   = boundary | ~busy;
  assign active   = (req | susp_q) & ~cnt_done;
  assign last_sel = boundary ? cur_idx : last_q;

  dma_arb_fixed_pick #(.NCH(NCH)) u_fixed (
    .cand (active),
    .pick (pick_fixed)
  );

  dma_arb_rot_pick #(.NCH(NCH), .CW(CW)) u_rot (
    .cand (active),
    .last (last_sel),
    .pick (pick_rot)
  );

  always_comb begin
    if (!decide)                   grant_nx = grant_q;
    else if (mode == PRIO_ROTATE)  grant_nx = pick_rot;
    else                           grant_nx = pick_fixed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      last_q  <= CW'(NCH - 1);
    end else begin
      grant_q <= grant_nx;
      if (boundary) last_q <= cur_idx;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma_arb_chan_track u_trk (
      .clk      (clk),
      .rst      (rst),
      .decide   (decide),
      .boundary (boundary),
      .held     (grant_q[g]),
      .burst    (burst_mode[g]),
      .active   (active[g]),
      .win      (grant_nx[g]),
      .cnt_done (cnt_done[g]),
      .susp     (susp_q[g]),
      .res      (res_q[g])
    );
  end

  assign grant     = grant_q;
  assign suspended = susp_q;
  assign resumed   = res_q;

endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           rr_mode,
  input logic [NCH-1:0] req,
  input logic [NCH-1:0] cnt_done,
  input logic           unit_done,
  input logic [NCH-1:0] grant,
  input logic [NCH-1:0] suspended,
  input logic [NCH-1:0] resumed
);

  p_onehot_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!unit_done && grant != '0) |=> $stable(grant));

  p_fixed_top_r3: assert property (@(posedge clk) disable iff (rst)
    (!rr_mode && unit_done && grant != '0 && req[0] && !cnt_done[0]) |=> grant[0]);

  p_susp_not_granted_r4: assert property (@(posedge clk) disable iff (rst)
    (suspended & grant) == '0);

  p_alternate_r7: assert property (@(posedge clk) disable iff (rst)
    (rr_mode && unit_done && grant[0] && req[1] && !cnt_done[1]) |=> grant[1]);

  p_resume_granted_r11: assert property (@(posedge clk) disable iff (rst)
    (resumed & ~grant) == '0);

  p_resume_single_r11: assert property (@(posedge clk) disable iff (rst)
    (resumed != '0) |=> (resumed == '0));

endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.NCH(NCH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rr_mode   (rr_mode),
  .req       (req),
  .cnt_done  (cnt_done),
  .unit_done (unit_done),
  .grant     (grant),
  .suspended (suspended),
  .resumed   (resumed)
);

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NV  = 22;

  // {tag[4], rr, req[4], burst[4], cdone[4], ud, exp_grant[4], exp_susp[4], exp_res[4]}
  localparam logic [29:0] VEC [NV] = '{
    {4'd3,  1'b0, 4'b0010, 4'b0010, 4'b0000, 1'b0, 4'b0010, 4'b0000, 4'b0000}, // R3 idle grant ch1
    {4'd2,  1'b0, 4'b0010, 4'b0010, 4'b0000, 1'b0, 4'b0010, 4'b0000, 4'b0000}, // R2 hold
    {4'd2,  1'b0, 4'b0011, 4'b0010, 4'b0000, 1'b0, 4'b0010, 4'b0000, 4'b0000}, // R2 no preempt mid-unit
    {4'd4,  1'b0, 4'b0011, 4'b0010, 4'b0000, 1'b1, 4'b0001, 4'b0010, 4'b0000}, // R4 preempt, ch1 suspended
    {4'd5,  1'b0, 4'b0001, 4'b0010, 4'b0000, 1'b1, 4'b0001, 4'b0010, 4'b0000}, // R5 ch0 keeps until count done
    {4'd9,  1'b0, 4'b0001, 4'b0010, 4'b0001, 1'b1, 4'b0010, 4'b0000, 4'b0010}, // R9 R5 R11 resume w/o req
    {4'd2,  1'b0, 4'b0000, 4'b0010, 4'b0000, 1'b0, 4'b0010, 4'b0000, 4'b0000}, // R2
    {4'd10, 1'b0, 4'b0000, 4'b0010, 4'b0010, 1'b1, 4'b0000, 4'b0000, 4'b0000}, // R10 count done
    {4'd1,  1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0000}, // R1 idle
    {4'd3,  1'b0, 4'b1000, 4'b0000, 4'b0000, 1'b0, 4'b1000, 4'b0000, 4'b0000}, // R3
    {4'd8,  1'b0, 4'b1100, 4'b0000, 4'b0000, 1'b1, 4'b0100, 4'b0000, 4'b0000}, // R8 steal not suspended
    {4'd8,  1'b0, 4'b1100, 4'b0000, 4'b0100, 1'b1, 4'b1000, 4'b0000, 4'b0000}, // R8 rejoins
    {4'd10, 1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b1, 4'b0000, 4'b0000, 4'b0000}, // R10 req drop
    {4'd6,  1'b1, 4'b0011, 4'b0011, 4'b0000, 1'b0, 4'b0001, 4'b0000, 4'b0000}, // R6 after ch3 -> ch0
    {4'd7,  1'b1, 4'b0011, 4'b0011, 4'b0000, 1'b1, 4'b0010, 4'b0001, 4'b0000}, // R7
    {4'd11, 1'b1, 4'b0011, 4'b0011, 4'b0000, 1'b1, 4'b0001, 4'b0010, 4'b0001}, // R11 R7
    {4'd10, 1'b1, 4'b0011, 4'b0011, 4'b0010, 1'b1, 4'b0001, 4'b0000, 4'b0000}, // R10 done clears susp
    {4'd10, 1'b1, 4'b0001, 4'b0011, 4'b0001, 1'b1, 4'b0000, 4'b0000, 4'b0000}, // R10
    {4'd6,  1'b1, 4'b1000, 4'b1001, 4'b0000, 1'b0, 4'b1000, 4'b0000, 4'b0000}, // R6 search after ch0
    {4'd4,  1'b1, 4'b1001, 4'b1001, 4'b0000, 1'b1, 4'b0001, 4'b1000, 4'b0000}, // R4 rotating
    {4'd11, 1'b1, 4'b0001, 4'b1001, 4'b0000, 1'b1, 4'b1000, 4'b0001, 4'b1000}, // R11 R9
    {4'd10, 1'b1, 4'b0000, 4'b1001, 4'b1001, 1'b1, 4'b0000, 4'b0000, 4'b0000}  // R10
  };

  logic           clk = 1'b0;
  logic           rst;
  logic           rr_mode;
  logic [NCH-1:0] req, burst_mode, cnt_done;
  logic           unit_done;
  logic [NCH-1:0] grant, suspended, resumed;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dma_prio_arbiter #(.NCH(NCH)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .rr_mode    (rr_mode),
    .req        (req),
    .burst_mode (burst_mode),
    .cnt_done   (cnt_done),
    .unit_done  (unit_done),
    .grant      (grant),
    .suspended  (suspended),
    .resumed    (resumed)
  );

  task automatic check(input string tag, input string what,
                       input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic [NCH-1:0] rq, input logic [NCH-1:0] bm,
                      input logic [NCH-1:0] cd, input logic ud);
    rr_mode = r; req = rq; burst_mode = bm; cnt_done = cd; unit_done = ud;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    rr_mode = 1'b0; req = '0; burst_mode = '0; cnt_done = '0; unit_done = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset state
    check("R1", "grant after reset", grant, '0);
    check("R1", "suspended after reset", suspended, '0);
    check("R1", "resumed after reset", resumed, '0);

    for (int v = 0; v < NV; v++) begin
      string tg;
      tg = $sformatf("R%0d", VEC[v][29:26]);
      step(VEC[v][25], VEC[v][24:21], VEC[v][20:17], VEC[v][16:13], VEC[v][12]);
      check(tg, $sformatf("grant v%0d", v), grant, VEC[v][11:8]);
      check(tg, $sformatf("suspended v%0d", v), suspended, VEC[v][7:4]);
      check(tg, $sformatf("resumed v%0d", v), resumed, VEC[v][3:0]);
      n_chk++;
      if ($countones(grant) > 1) begin
        n_fail++;
        $display("FAIL R1 one-hot v%0d: actual %b expected at most one bit", v, grant);
      end
    end

    // R1: reset in the middle of a suspended burst
    step(1'b0, 4'b0100, 4'b0100, 4'b0000, 1'b0);
    step(1'b0, 4'b0110, 4'b0100, 4'b0000, 1'b1);
    check("R4", "grant ch1 preempts ch2", grant, 4'b0010);
    check("R4", "ch2 suspended", suspended, 4'b0100);
    do_reset();
    check("R1", "grant cleared by reset", grant, '0);
    check("R1", "suspended cleared by reset", suspended, '0);

    // R6: rotating mode starts with channel 0 highest after reset
    step(1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b0);
    check("R6", "rotate start ch0", grant, 4'b0001);
    step(1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b1);
    check("R6", "rotate next ch1", grant, 4'b0010);
    step(1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b1);
    check("R6", "rotate next ch2", grant, 4'b0100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule